// File: doc/BRIEF.md
# High-Side Supply Undervoltage Lockout with Edge Re-arm

This block guards the high-side output of one half-bridge gate-driver channel against a sagging floating supply. Two digital flags from external comparators report the supply state: `sup_below_trip` is high while the supply sits under the lower (trip) threshold, and `sup_above_rst` is high while it sits over the upper (release) threshold. A drop must persist for longer than a programmable number of clock cycles before the high side is locked, so that short dips from switching noise are ignored.

Once locked, the high-side command is forced low. The lock is released only by the upper threshold flag, which gives the two-threshold hysteresis. After release the high-side output does not resume on a command level that happens to be high. It waits for the next rising edge of the command. The low-side path passes through untouched, and the lockout never drives any shared fault signal. At reset the block starts locked, as if the supply had not yet come up.

Top module: `hs_uvlo_gate`

## Requirements
- R1: When `sup_below_trip` is sampled high on more than FILT_CYC consecutive rising clock edges, `uv_lock` is high after the (FILT_CYC+1)-th such edge.
- R2: A run of FILT_CYC or fewer consecutive high samples of `sup_below_trip` does not set `uv_lock`, and the run count restarts whenever the flag is sampled low, so two short runs split by one low sample do not add up.
- R3: While `uv_lock` is high, `hs_out` is low whatever `hs_cmd` does.
- R4: A locked block releases (`uv_lock` low after the edge) only on an edge where `sup_above_rst` is sampled high. `sup_below_trip` falling alone does not release it.
- R5: `ls_out` equals `ls_cmd` at all times, whether locked or not.
- R6: After a release, `hs_out` stays low until `hs_cmd` rises. A `hs_cmd` held high across the release keeps `hs_out` low.
- R7: After reset `uv_lock` is high and `hs_out` is low until a release per R4 and a rising command per R6.
- R8: Once re-armed by a rising `hs_cmd` and while unlocked, `hs_out` follows `hs_cmd` in the same cycle, including the cycle of the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_below_trip | input | 1 | High-side supply under trip threshold |
| sup_above_rst | input | 1 | High-side supply over release threshold |
| hs_cmd | input | 1 | Filtered high-side command |
| ls_cmd | input | 1 | Filtered low-side command |
| uv_lock | output | 1 | High-side undervoltage lockout active |
| hs_out | output | 1 | Gated high-side drive |
| ls_out | output | 1 | Low-side drive (pass-through) |

## Verification
The hardest condition to reach from the ports is the exact boundary of the drop filter: a run of FILT_CYC samples must leave the lock clear while FILT_CYC+1 must set it. The bench drives the trip flag on falling edges and counts rising edges exactly, so both lengths are applied against the same threshold. It also applies two back-to-back short runs split by one low sample, to show that they do not add up. The second subtle case is a release while the command is already high. The bench raises the command during lockout, holds it through the release, and shows that the output stays low until a fresh rising edge.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;
  // Width of a counter that must reach lim
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // A drop qualifies once lim earlier consecutive samples were seen and the
  // current sample is still below trip
  function automatic logic drop_qualified(int unsigned prior_run,
                                          int unsigned lim, logic below_now);
    return below_now && (prior_run >= lim);
  endfunction
endpackage

// File: rtl/uvlo_filter.sv
module uvlo_filter #(
  parameter int unsigned FILT_CYC = 16,
  localparam int unsigned CW = uvlo_pkg::cnt_width(FILT_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_trip,
  output logic trip_evt
);
  logic [CW-1:0] run_q;

  assign trip_evt = uvlo_pkg::drop_qualified(int'(run_q), FILT_CYC, below_trip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (!below_trip)
      run_q <= '0;
    else if (run_q != CW'(FILT_CYC))
      run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/uvlo_latch.sv
module uvlo_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_evt,
  input  logic above_rst,
  output logic lock,
  output logic release_evt
);
  // Trip has priority over release when the flags disagree
  assign release_evt = lock && above_rst && !trip_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock <= 1'b1;
    else if (trip_evt)
      lock <= 1'b1;
    else if (release_evt)
      lock <= 1'b0;
  end
endmodule

// File: rtl/hs_rearm_gate.sv
module hs_rearm_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic cmd,
  output logic drive,
  output logic cmd_rise
);
  logic cmd_q;
  logic armed_q;

  assign cmd_rise = cmd && !cmd_q;
  assign drive    = !lock && cmd && (armed_q || cmd_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cmd_q <= cmd;
      if (lock)
        armed_q <= 1'b0;
      else if (cmd_rise)
        armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hs_uvlo_gate.sv
module hs_uvlo_gate #(
  parameter int unsigned FILT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_below_trip,
  input  logic sup_above_rst,
  input  logic hs_cmd,
  input  logic ls_cmd,
  output logic uv_lock,
  output logic hs_out,
  output logic ls_out
);
  logic trip_evt;
  logic release_evt;
  logic hin_rise;

  uvlo_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .below_trip(sup_below_trip), .trip_evt(trip_evt)
  );

  uvlo_latch u_latch (
    .clk(clk), .rst_n(rst_n), .trip_evt(trip_evt), .above_rst(sup_above_rst),
    .lock(uv_lock), .release_evt(release_evt)
  );

  hs_rearm_gate u_gate (
    .clk(clk), .rst_n(rst_n), .lock(uv_lock), .cmd(hs_cmd),
    .drive(hs_out), .cmd_rise(hin_rise)
  );

  // Low side is never touched by the high-side lockout
  assign ls_out = ls_cmd;
endmodule

// File: rtl/hs_uvlo_chk.sv
module hs_uvlo_chk #(
  parameter int unsigned FILT_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sup_below_trip,
  input logic sup_above_rst,
  input logic hs_cmd,
  input logic uv_lock,
  input logic hs_out,
  input logic trip_evt,
  input logic release_evt,
  input logic hin_rise
);
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_run <= 0;
    else if (!sup_below_trip)
      low_run <= 0;
    else if (low_run <= FILT_CYC)
      low_run <= low_run + 1;
  end

  p_trip_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |-> (low_run >= FILT_CYC));

  p_lock_from_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_lock) |-> $past(trip_evt));

  p_hout_low_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uv_lock |-> !hs_out);

  p_release_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv_lock) |-> ($past(sup_above_rst) && $past(release_evt)));

  p_rise_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_out) |-> ($rose(hs_cmd) && hin_rise));

  p_follow_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_lock && $past(hs_out) && hs_cmd) |-> hs_out);
endmodule

bind hs_uvlo_gate hs_uvlo_chk #(.FILT_CYC(FILT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sup_below_trip(sup_below_trip),
  .sup_above_rst(sup_above_rst), .hs_cmd(hs_cmd), .uv_lock(uv_lock),
  .hs_out(hs_out), .trip_evt(trip_evt), .release_evt(release_evt),
  .hin_rise(hin_rise)
);

// File: tb/hs_uvlo_gate_tb.sv
module hs_uvlo_gate_tb;
  localparam int unsigned FILT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below = 1'b0;
  logic above = 1'b0;
  logic hin = 1'b0;
  logic lin = 1'b0;
  logic lock, hout, lout;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  hs_uvlo_gate #(.FILT_CYC(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .sup_below_trip(below), .sup_above_rst(above),
    .hs_cmd(hin), .ls_cmd(lin), .uv_lock(lock), .hs_out(hout), .ls_out(lout)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Advance n rising edges; return just after the following falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R7 lock at reset", lock, 1'b1);
    chk("R7 hout at reset", hout, 1'b0);
    hin = 1'b1; step(1);
    chk("R7 hout locked after reset", hout, 1'b0);
    chk("R3 hout low while locked", hout, 1'b0);
    hin = 1'b0; step(1);
  endtask

  task automatic t_release();
    below = 1'b0; step(2);
    chk("R4 no release without above flag", lock, 1'b1);
    above = 1'b1; step(1);
    chk("R4 released by above flag", lock, 1'b0);
    chk("R6 hout waits for edge", hout, 1'b0);
  endtask

  task automatic t_arm();
    hin = 1'b1; #1;
    chk("R8 hout on rising edge", hout, 1'b1);
    step(1);
    chk("R8 hout follows high", hout, 1'b1);
    hin = 1'b0; #1;
    chk("R8 hout follows low", hout, 1'b0);
    step(1);
    hin = 1'b1; #1;
    chk("R8 hout re-follows", hout, 1'b1);
    step(1);
  endtask

  task automatic t_short_drop();
    above = 1'b0; below = 1'b1;
    step(FILT);
    below = 1'b0; #1;
    chk("R2 FILT-cycle drop no lock", lock, 1'b0);
    step(1);
    below = 1'b1; step(FILT);
    below = 1'b0; step(1);
    chk("R2 split drops no lock", lock, 1'b0);
    chk("R2 hout still driven", hout, 1'b1);
  endtask

  task automatic t_long_drop();
    lin = 1'b1;
    below = 1'b1;
    step(FILT);
    chk("R1 not yet at FILT", lock, 1'b0);
    step(1);
    chk("R1 lock after FILT+1", lock, 1'b1);
    chk("R3 hout forced low", hout, 1'b0);
    chk("R5 lout high during lock", lout, 1'b1);
    lin = 1'b0; #1;
    chk("R5 lout low during lock", lout, 1'b0);
    hin = 1'b0; step(1);
    hin = 1'b1; step(1);
    chk("R3 rising hin ignored when locked", hout, 1'b0);
  endtask

  task automatic t_held_release();
    below = 1'b0; above = 1'b1; step(1);
    chk("R4 released", lock, 1'b0);
    chk("R6 held hin keeps hout low", hout, 1'b0);
    step(3);
    chk("R6 still low while held", hout, 1'b0);
    hin = 1'b0; step(1);
    hin = 1'b1; #1;
    chk("R6 fresh edge drives", hout, 1'b1);
    lin = 1'b1; #1;
    chk("R5 lout follows unlocked", lout, 1'b1);
    step(1);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_release();
    t_arm();
    t_short_drop();
    t_long_drop();
    t_held_release();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule